// File: doc/BRIEF.md
# Opcode Fetch and Microcode Dispatch Sequencer

This block is the front end of a microcoded interpreter engine. It reads one 8-bit intermediate-language opcode from an external program memory and advances a 16-bit program counter. It then jumps the 10-bit microprogram counter to the start of the routine that serves that opcode. The routines themselves are small stubs here: each runs a fixed number of steps and returns to the fetch routine. The datapath behind them is not part of the block.

The jump target comes from a 256-entry dispatch table. The table is computed from an ordered list of wildcard opcode patterns. Each pattern holds a value, a care mask and a microaddress. Patterns are applied in list order, so a later match replaces an earlier one. If the memory reports the fetched address as invalid, the dispatch step goes to an error routine instead of the table target. Unknown opcodes reach the same error routine through a bad-opcode stub. On arrival there, the block records the opcode and its fetch address and then stays parked until reset.

Some microsteps are marked as trace calls. When tracing is off, each one takes a single cycle. When tracing is on, each one is preceded by exactly one stall cycle in which a hook output is raised and nothing else changes.

Top module: `ild_fetch_dispatch`

## Requirements
- R1: Synchronous reset, active high, sets the microprogram counter to 0x000 and the IL program counter to 0x0000. It also clears the error flag, the error opcode and the error address.
- R2: The fetch routine runs microaddresses 0x000, 0x001, 0x002 and 0x003 in that order. At 0x002, `il_op` takes `il_rdata` read at address `il_addr` (which equals the IL program counter), and the IL program counter grows by one on the same clock edge.
- R3: At 0x003 (the fork step), `exec_clear` is high for exactly that one cycle. If the fetch was valid, the next microaddress is the dispatch entry for `il_op`.
- R4: If `il_valid` was low when the opcode was loaded, the fork step goes to the error routine at 0x00C instead of the dispatch entry.
- R5: Dispatch entries come from patterns applied in this order, with later patterns winning. Any opcode maps to 0x00D. Opcodes 0x00 to 0x07 map to 0x00E. Opcode 0x00 alone maps to 0x011. Opcodes 0x08, 0x09, 0x0A, 0x0B and 0x0C map to 0x013, 0x015, 0x019, 0x01D and 0x021.
- R6: The bad-opcode stub at 0x00D takes one cycle and then goes to 0x00C.
- R7: The cycle after the counter first sits at 0x00C, `err` rises. At the same time, `err_op` and `err_addr` take the current opcode and the IL address it was read from. The counter stays at 0x00C, and all three outputs hold until reset.
- R8: Trace steps are 0x000, 0x001, 0x002, 0x00E and 0x011. With `trace_en` low, each takes one cycle and `trace_hook` stays low. With `trace_en` high, each first spends one stall cycle with `trace_hook` high, during which the counter, `il_op` and the IL program counter do not change.
- R9: The routine stubs follow these paths and then return to 0x000. 0x00E→0x00F→0x010. 0x011→0x012. 0x013→0x014. Each of 0x015, 0x019, 0x01D and 0x021 steps up by one, for four steps in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Enables the one-cycle stall before each trace step |
| il_addr | output | 16 | IL program counter, used as the opcode read address |
| il_rdata | input | 8 | Opcode byte at `il_addr` |
| il_valid | input | 1 | High when `il_addr` is a valid IL address |
| upc | output | 10 | Microprogram counter |
| il_op | output | 8 | Instruction register |
| exec_clear | output | 1 | Clear pulse for the temporary register and the ALU, raised in the fork step |
| trace_hook | output | 1 | High during a trace stall cycle |
| err | output | 1 | Internal error latched |
| err_op | output | 8 | Opcode held at error entry |
| err_addr | output | 16 | IL address of that opcode |

## Verification
The assertions take three things for granted. `il_rdata` and `il_valid` are combinational functions of `il_addr` and are settled in the load step. `trace_en` does not change while a trace step is under way. Reset is held across at least one clock edge. The bench models the program memory as a byte array addressed by `il_addr`, with validity given by an address limit. It changes `trace_en`, the memory contents and the limit only while reset is asserted or between instructions, at the first step of a fetch, so the stall and load timing the assertions rely on always holds.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int OPW  = 8;
    localparam int UAW  = 10;
    localparam int NPAT = 8;

    typedef logic [UAW-1:0] uaddr_t;
    typedef logic [OPW-1:0] opcode_t;

    typedef enum logic [1:0] {
        NX_SEQ  = 2'd0,
        NX_GOTO = 2'd1,
        NX_FORK = 2'd2
    } nxt_e;

    typedef struct packed {
        nxt_e   nxt;
        uaddr_t tgt;
        logic   trc;
        logic   ld;
        logic   clr;
    } uword_t;

    typedef struct packed {
        opcode_t val;
        opcode_t care;
        uaddr_t  tgt;
    } pat_t;

    localparam uaddr_t UA_FETCH = 10'h000;
    localparam uaddr_t UA_LOAD  = 10'h002;
    localparam uaddr_t UA_FORK  = 10'h003;
    localparam uaddr_t UA_ERR   = 10'h00C;
    localparam uaddr_t UA_BAD   = 10'h00D;

    // Ordered pattern list; later entries override earlier ones
    function automatic pat_t pat_at(int i);
        pat_t p;
        case (i)
            0:       p = '{val: 8'h00, care: 8'h00, tgt: UA_BAD};
            1:       p = '{val: 8'h00, care: 8'hF8, tgt: 10'h00E};
            2:       p = '{val: 8'h00, care: 8'hFF, tgt: 10'h011};
            3:       p = '{val: 8'h08, care: 8'hFF, tgt: 10'h013};
            4:       p = '{val: 8'h09, care: 8'hFF, tgt: 10'h015};
            5:       p = '{val: 8'h0A, care: 8'hFF, tgt: 10'h019};
            6:       p = '{val: 8'h0B, care: 8'hFF, tgt: 10'h01D};
            7:       p = '{val: 8'h0C, care: 8'hFF, tgt: 10'h021};
            default: p = '{val: 8'h00, care: 8'h00, tgt: UA_BAD};
        endcase
        return p;
    endfunction

    function automatic uaddr_t dispatch_lookup(opcode_t op);
        uaddr_t r;
        pat_t   p;
        r = UA_BAD;
        for (int i = 0; i < NPAT; i++) begin
            p = pat_at(i);
            if (((op ^ p.val) & p.care) == '0) r = p.tgt;
        end
        return r;
    endfunction

    // Microprogram contents; unused addresses fall into the error routine
    function automatic uword_t ucode_at(uaddr_t a);
        uword_t w;
        w = '{nxt: NX_GOTO, tgt: UA_ERR, trc: 1'b0, ld: 1'b0, clr: 1'b0};
        case (a)
            10'h000, 10'h001: begin w.nxt = NX_SEQ; w.trc = 1'b1; end
            UA_LOAD:          begin w.nxt = NX_SEQ; w.trc = 1'b1; w.ld = 1'b1; end
            UA_FORK:          begin w.nxt = NX_FORK; w.clr = 1'b1; end
            10'h00E, 10'h011: begin w.nxt = NX_SEQ; w.trc = 1'b1; end
            10'h00F:          w.nxt = NX_SEQ;
            10'h010, 10'h012: w.tgt = UA_FETCH;
            default: begin
                if (a >= 10'h013 && a <= 10'h024) begin
                    if (a[1:0] == 2'b00) w.tgt = UA_FETCH;
                    else                 w.nxt = NX_SEQ;
                end
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ild_dispatch_map.sv
module ild_dispatch_map
    import ild_pkg::*;
(
    input  opcode_t op,
    output uaddr_t  start
);
    assign start = dispatch_lookup(op);
endmodule

// File: rtl/ild_ustore.sv
module ild_ustore
    import ild_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  uaddr_t upc,
    output uword_t uw
);
    localparam int IW = $clog2(DEPTH);

    uword_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = ucode_at(uaddr_t'(g));
    end

    always_comb begin
        uw = ucode_at(UA_ERR);
        if (upc < uaddr_t'(DEPTH)) uw = rom[upc[IW-1:0]];
    end
endmodule

// File: rtl/ild_useq.sv
module ild_useq
    import ild_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   trace_en,
    input  uword_t uw,
    input  uaddr_t start,
    input  logic   op_ok,
    output uaddr_t upc,
    output logic   hold
);
    uaddr_t upc_q;
    uaddr_t nxt;
    logic   stall_q;

    assign hold = uw.trc && trace_en && !stall_q;
    assign upc  = upc_q;

    always_comb begin
        case (uw.nxt)
            NX_SEQ:  nxt = upc_q + uaddr_t'(1);
            NX_GOTO: nxt = uw.tgt;
            NX_FORK: nxt = op_ok ? start : UA_ERR;
            default: nxt = UA_ERR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q   <= UA_FETCH;
            stall_q <= 1'b0;
        end else begin
            stall_q <= hold;
            if (!hold) upc_q <= nxt;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(hold) |-> $stable(upc_q));

    // R8
    stall_once_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(hold) |-> !hold);

    // R4
    err_route_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(uw.nxt == NX_FORK) && !$past(hold) && !$past(op_ok)
        |-> upc_q == UA_ERR);

    // R6
    badop_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(upc_q) == UA_BAD |-> upc_q == UA_ERR);
endmodule

// File: rtl/ild_fetch_dispatch.sv
module ild_fetch_dispatch
    import ild_pkg::*;
#(
    parameter int ILW      = 16,
    parameter int PC_RESET = 0,
    parameter int UDEPTH   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trace_en,
    output logic [ILW-1:0]    il_addr,
    input  logic [OPW-1:0]    il_rdata,
    input  logic              il_valid,
    output logic [UAW-1:0]    upc,
    output logic [OPW-1:0]    il_op,
    output logic              exec_clear,
    output logic              trace_hook,
    output logic              err,
    output logic [OPW-1:0]    err_op,
    output logic [ILW-1:0]    err_addr
);
    uword_t         uw;
    uaddr_t         start;
    uaddr_t         upc_w;
    logic           hold;
    logic           load_fire;
    opcode_t        ir_q;
    logic [ILW-1:0] pc_q;
    logic [ILW-1:0] op_addr_q;
    logic           op_ok_q;
    logic           err_q;
    opcode_t        err_op_q;
    logic [ILW-1:0] err_addr_q;

    ild_ustore #(.DEPTH(UDEPTH)) u_store (
        .upc (upc_w),
        .uw  (uw)
    );

    ild_dispatch_map u_map (
        .op    (ir_q),
        .start (start)
    );

    ild_useq u_seq (
        .clk      (clk),
        .rst      (rst),
        .trace_en (trace_en),
        .uw       (uw),
        .start    (start),
        .op_ok    (op_ok_q),
        .upc      (upc_w),
        .hold     (hold)
    );

    assign load_fire = uw.ld && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= ILW'(PC_RESET);
            ir_q       <= '0;
            op_addr_q  <= '0;
            op_ok_q    <= 1'b0;
            err_q      <= 1'b0;
            err_op_q   <= '0;
            err_addr_q <= '0;
        end else begin
            if (load_fire) begin
                ir_q      <= il_rdata;
                pc_q      <= pc_q + ILW'(1);
                op_addr_q <= pc_q;
                op_ok_q   <= il_valid;
            end
            if (upc_w == UA_ERR && !err_q) begin
                err_q      <= 1'b1;
                err_op_q   <= ir_q;
                err_addr_q <= op_addr_q;
            end
        end
    end

    assign il_addr    = pc_q;
    assign upc        = upc_w;
    assign il_op      = ir_q;
    assign exec_clear = uw.clr && !hold;
    assign trace_hook = hold;
    assign err        = err_q;
    assign err_op     = err_op_q;
    assign err_addr   = err_addr_q;

    // R2
    load_inc_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(load_fire)
        |-> pc_q == $past(pc_q) + ILW'(1) && ir_q == $past(il_rdata));

    // R3
    fork_target_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(upc_w) == UA_FORK && $past(op_ok_q)
        |-> upc_w == dispatch_lookup($past(ir_q)));

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(err_q)
        |-> err_q && $stable(err_op_q) && $stable(err_addr_q) && upc_w == UA_ERR);

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(hold) |-> $stable(pc_q) && $stable(ir_q));
endmodule

// File: tb/ild_fetch_dispatch_tb.sv
`timescale 1ns/1ps
module ild_fetch_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_en = 1'b0;
    logic [15:0] il_addr;
    logic [7:0]  il_rdata;
    logic        il_valid;
    logic [9:0]  upc;
    logic [7:0]  il_op;
    logic        exec_clear;
    logic        trace_hook;
    logic        err;
    logic [7:0]  err_op;
    logic [15:0] err_addr;

    logic [7:0] imem [256];
    int valid_lim = 256;
    int checks = 0;
    int fails = 0;
    int exp_q[$];
    int exp_pc;
    bit done = 0;

    always #5 clk = ~clk;

    assign il_rdata = imem[il_addr[7:0]];
    assign il_valid = (int'(il_addr) < valid_lim);

    ild_fetch_dispatch u_dut (
        .clk(clk), .rst(rst), .trace_en(trace_en),
        .il_addr(il_addr), .il_rdata(il_rdata), .il_valid(il_valid),
        .upc(upc), .il_op(il_op), .exec_clear(exec_clear),
        .trace_hook(trace_hook), .err(err), .err_op(err_op), .err_addr(err_addr)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Requirement-level dispatch expectation (R5)
    function automatic int exp_target(int op);
        if (op == 0) return 'h011;
        if (op < 8) return 'h00E;
        case (op)
            8:  return 'h013;
            9:  return 'h015;
            10: return 'h019;
            11: return 'h01D;
            12: return 'h021;
            default: return 'h00D;
        endcase
    endfunction

    // entry encoding: [9:0] upc, bit12 hook, bit13 clear
    task automatic push_step(int a, bit trc);
        if (trc && trace_en) exp_q.push_back(a | (1 << 12));
        exp_q.push_back(a);
    endtask

    task automatic push_fetch();
        push_step(0, 1);
        push_step(1, 1);
        push_step(2, 1);
        exp_q.push_back(3 | (1 << 13));
    endtask

    // R9 stub paths
    task automatic push_routine(int t);
        case (t)
            'h00E: begin push_step('h00E, 1); push_step('h00F, 0); push_step('h010, 0); end
            'h011: begin push_step('h011, 1); push_step('h012, 0); end
            'h013: begin push_step('h013, 0); push_step('h014, 0); end
            default: for (int k = 0; k < 4; k++) push_step(t + k, 0);
        endcase
    endtask

    task automatic run_q(string req);
        while (exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            check({req, " upc"}, int'(upc), e & 'h3FF);
            check("R8 trace_hook", int'(trace_hook), (e >> 12) & 1);
            check("R3 exec_clear", int'(exec_clear), (e >> 13) & 1);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(bit tr);
        @(negedge clk);
        rst = 1'b1;
        trace_en = tr;
        @(negedge clk);
        rst = 1'b0;
        exp_pc = 0;
    endtask

    task automatic run_program(bit tr);
        byte ops[8] = '{8'h00, 8'h03, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h07};
        for (int i = 0; i < 8; i++) imem[i] = ops[i];
        valid_lim = 256;
        do_reset(tr);
        for (int i = 0; i < 8; i++) begin
            push_fetch();
            push_routine(exp_target(int'(ops[i])));
            run_q("R9");
            exp_pc++;
            check("R2 il_addr", int'(il_addr), exp_pc);
            check("R2 il_op", int'(il_op), int'(ops[i]));
        end
        check("R9 back at fetch", int'(upc), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) imem[i] = 8'h00;
        do_reset(0);
        // R1 reset state
        check("R1 upc", int'(upc), 0);
        check("R1 il_addr", int'(il_addr), 0);
        check("R1 err", int'(err), 0);
        check("R1 err_op", int'(err_op), 0);
        check("R1 err_addr", int'(err_addr), 0);

        // R5 full opcode sweep
        for (int op = 0; op < 256; op++) begin
            imem[0] = 8'(op);
            valid_lim = 256;
            do_reset(0);
            push_fetch();
            exp_q.push_back(exp_target(op));
            run_q("R5");
        end

        // R2 R3 R9 program run, trace off then on (R8)
        run_program(0);
        run_program(1);

        // R4 R7 invalid address diverts to error routine
        imem[0] = 8'h01; imem[1] = 8'h08; imem[2] = 8'h09;
        valid_lim = 2;
        do_reset(0);
        push_fetch(); push_routine('h00E); run_q("R3");
        push_fetch(); push_routine('h013); run_q("R3");
        push_fetch(); exp_q.push_back('h00C); run_q("R4");
        check("R7 err", int'(err), 1);
        check("R7 err_op", int'(err_op), 'h09);
        check("R7 err_addr", int'(err_addr), 2);
        check("R7 parked", int'(upc), 'h00C);
        repeat (6) @(negedge clk);
        check("R7 err held", int'(err), 1);
        check("R7 still parked", int'(upc), 'h00C);
        check("R7 err_op held", int'(err_op), 'h09);
        do_reset(0);
        check("R1 err cleared", int'(err), 0);
        check("R1 err_addr cleared", int'(err_addr), 0);

        // R6 R7 bad opcode path, trace on
        imem[0] = 8'h40; imem[1] = 8'h01; imem[2] = 8'hFF;
        valid_lim = 256;
        do_reset(1);
        push_fetch(); exp_q.push_back('h00D); exp_q.push_back('h00C); run_q("R6");
        check("R7 err badop", int'(err), 1);
        check("R7 err_op badop", int'(err_op), 'h40);
        check("R7 err_addr badop", int'(err_addr), 0);

        // R6 bad opcode at later address
        do_reset(0);
        imem[0] = 8'h02; imem[1] = 8'hFF;
        push_fetch(); push_routine('h00E); run_q("R9");
        push_fetch(); exp_q.push_back('h00D); exp_q.push_back('h00C); run_q("R6");
        check("R7 err_op late", int'(err_op), 'hFF);
        check("R7 err_addr late", int'(err_addr), 1);
        check("R2 il_addr after bad", int'(il_addr), 2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule